// File: doc/BRIEF.md
# I2C Pad Recovery Override

This block sits between an I2C controller and the two open-drain bus pads, clock (SCL) and data (SDA). Normally the controller's drive-low requests reach the pads unchanged. Software can set one mode bit to take both pads away from the controller. The pads then behave as two general-purpose pins. Each pin has a direction bit and an output latch. The latch is written through separate write-one-to-set and write-one-to-clear addresses. Software can then clock a stuck bus free by hand. The recovery pulse sequence itself is left to software.

Because the pads are open-drain, the block drives a pad low or releases it; it never drives a pad high. Each pad's live level is brought into the clock domain by a two-flop synchroniser. It is readable in both modes, so software can watch the bus while it toggles the clock. Pin index 0 is SCL and index 1 is SDA on every vector port.

Top module: `i2c_pad_override`

## Requirements
- R1: After reset the block is in controller mode, both pins are inputs and both output latches hold 1 (released). Both synchronised levels read 1 until pad levels arrive.
- R2: In controller mode (mode bit 0) each pad's drive-low enable equals the controller's request for that pin in the same cycle. Direction and latch contents have no effect on the pads.
- R3: A write to address 0 takes data bit 0 as the mode bit. A 1 hands both pads to the pin registers and a 0 returns them to the controller. The other data bits are ignored.
- R4: In pin mode a pad is pulled low exactly when its direction bit is 1 and its latch is 0. Controller requests have no effect.
- R5: A write to address 1 loads the direction bits. Bit 0 makes SCL an output and bit 1 makes SDA an output.
- R6: A write to address 2 sets each latch whose data bit is 1, which releases that pad. Latches whose data bit is 0 keep their value.
- R7: A write to address 3 clears each latch whose data bit is 1, which pulls that pad low if it is an output. Latches whose data bit is 0 keep their value.
- R8: Each synchronised level equals its pad input as sampled two clock edges earlier, in both modes.
- R9: In pin mode a pin whose direction bit is 0 is never pulled low, whatever its latch holds.
- R10: While the write enable is low, the address and data inputs change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken on the rising edge |
| wr_addr | input | 2 | Register select: 0 mode, 1 direction, 2 set, 3 clear |
| wr_data | input | NPINS | Write data, bit 0 SCL, bit 1 SDA |
| ctl_low | input | NPINS | Controller drive-low requests |
| pad_in | input | NPINS | Raw pad levels |
| pad_low | output | NPINS | Pad pull-down enables (1 pulls the pad low) |
| pin_level | output | NPINS | Synchronised pad levels |

## Verification
The pad enables are combinational from the controller requests and from registers that load on the edge a write is taken. A write therefore shows on the pads right after that edge, and a controller request shows in the same cycle. Each synchronised level carries the pad value sampled two edges before. The bench drives every input just after a falling edge and advances its reference model at the rising edge. It compares both outputs one nanosecond later, so each result is read in the cycle it is due and never on an edge.

// File: rtl/i2c_pad_pkg.sv
// Shared definitions for the I2C pad override block.
// Assumes a two-bit register select; pin 0 is SCL and pin 1 is SDA.
package i2c_pad_pkg;

    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int PIN_SCL     = 0;
    localparam int PIN_SDA     = 1;

    typedef enum logic [ADDR_W-1:0] {
        PAD_REG_MODE = 2'd0,
        PAD_REG_DIR  = 2'd1,
        PAD_REG_SET  = 2'd2,
        PAD_REG_CLR  = 2'd3
    } pad_reg_e;

endpackage

// File: rtl/i2c_pad_regs.sv
// Holds the mode bit, per-pin direction bits and per-pin output latches.
// Assumes one write per cycle; set and clear never collide because they
// use separate addresses. Latches reset to 1 so the pads start released.
module i2c_pad_regs
    import i2c_pad_pkg::*;
#(
    parameter int NPINS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [NPINS-1:0]        wr_data,
    output logic                    gpio_mode,
    output logic [NPINS-1:0]        dir_q,
    output logic [NPINS-1:0]        out_q
);

    pad_reg_e sel;
    assign sel = pad_reg_e'(wr_addr);

    // Register update: mode load, direction load, latch set and latch clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gpio_mode <= 1'b0;
            dir_q     <= '0;
            out_q     <= '1;
        end else if (wr_en) begin
            unique case (sel)
                PAD_REG_MODE: gpio_mode <= wr_data[0];
                PAD_REG_DIR:  dir_q     <= wr_data;
                PAD_REG_SET:  out_q     <= out_q | wr_data;
                PAD_REG_CLR:  out_q     <= out_q & ~wr_data;
            endcase
        end
    end

endmodule

// File: rtl/i2c_pad_sync.sv
// Brings each asynchronous pad level into the clock domain.
// Assumes the bus idles high, so the chains reset to 1.
module i2c_pad_sync
    import i2c_pad_pkg::*;
#(
    parameter int NPINS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] level
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [SYNC_STAGES-1:0] chain;

        // Shift the pad level through the synchroniser flops.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], pad_in[p]};
        end

        assign level[p] = chain[SYNC_STAGES-1];
    end

endmodule

// File: rtl/i2c_pad_drive.sv
// Chooses, per pin, between the controller request and the pin registers.
// Assumes open-drain pads: the only action is a pull-down enable.
module i2c_pad_drive #(
    parameter int NPINS = 2
) (
    input  logic             gpio_mode,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] out_q,
    input  logic [NPINS-1:0] ctl_low,
    output logic [NPINS-1:0] pad_low
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic gpio_low;
        // Pin mode pulls low only for an output with a cleared latch.
        assign gpio_low   = dir_q[p] & ~out_q[p];
        assign pad_low[p] = gpio_mode ? gpio_low : ctl_low[p];
    end

endmodule

// File: rtl/i2c_pad_override.sv
// Top of the I2C pad override: registers, pad mux and input synchronisers.
// Assumes writes come from a register decoder in the same clock domain.
module i2c_pad_override
    import i2c_pad_pkg::*;
#(
    parameter int NPINS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [NPINS-1:0]   wr_data,
    input  logic [NPINS-1:0]   ctl_low,
    input  logic [NPINS-1:0]   pad_in,
    output logic [NPINS-1:0]   pad_low,
    output logic [NPINS-1:0]   pin_level
);

    logic             gpio_mode;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] out_q;

    i2c_pad_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .gpio_mode (gpio_mode),
        .dir_q     (dir_q),
        .out_q     (out_q)
    );

    i2c_pad_drive #(.NPINS(NPINS)) u_drive (
        .gpio_mode (gpio_mode),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .ctl_low   (ctl_low),
        .pad_low   (pad_low)
    );

    i2c_pad_sync #(.NPINS(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .level  (pin_level)
    );

endmodule

// File: rtl/i2c_pad_override_chk.sv
// Property checker for the I2C pad override, bound to every instance.
// Assumes the synchroniser depth in the package is two.
module i2c_pad_override_chk
    import i2c_pad_pkg::*;
#(
    parameter int NPINS = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NPINS-1:0]   wr_data,
    input logic [NPINS-1:0]   ctl_low,
    input logic [NPINS-1:0]   pad_in,
    input logic [NPINS-1:0]   pad_low,
    input logic [NPINS-1:0]   pin_level,
    input logic               gpio_mode,
    input logic [NPINS-1:0]   dir_q,
    input logic [NPINS-1:0]   out_q
);

    logic [1:0] warm;

    // Count edges since reset so the two-edge history is valid.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd2) warm <= warm + 2'd1;
    end

    assert_ctl_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_mode |-> pad_low == ctl_low);

    assert_mode_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == PAD_REG_MODE |=> gpio_mode == $past(wr_data[0]));

    assert_ctl_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_mode && $stable(gpio_mode) && $stable(dir_q) && $stable(out_q)
        |-> $stable(pad_low));

    assert_dir_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == PAD_REG_DIR |=> dir_q == $past(wr_data));

    assert_set_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == PAD_REG_SET |=>
        ((out_q & $past(wr_data)) == $past(wr_data)) &&
        ((out_q & ~$past(wr_data)) == ($past(out_q) & ~$past(wr_data))));

    assert_clr_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == PAD_REG_CLR |=>
        ((out_q & $past(wr_data)) == '0) &&
        ((out_q & ~$past(wr_data)) == ($past(out_q) & ~$past(wr_data))));

    assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warm == 2'd2 |-> pin_level == $past(pad_in, 2));

    assert_input_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_mode |-> (pad_low & ~dir_q) == '0);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gpio_mode) && $stable(dir_q) && $stable(out_q));

endmodule

bind i2c_pad_override i2c_pad_override_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ctl_low   (ctl_low),
    .pad_in    (pad_in),
    .pad_low   (pad_low),
    .pin_level (pin_level),
    .gpio_mode (gpio_mode),
    .dir_q     (dir_q),
    .out_q     (out_q)
);

// File: tb/i2c_pad_override_bench.sv
// Bench for the I2C pad override: behavioural reference model compared
// with both outputs on every clock.
module i2c_pad_override_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [1:0] wr_data = '0;
    logic [1:0] ctl_low = '0;
    logic [1:0] pad_in = 2'b11;
    logic [1:0] pad_low;
    logic [1:0] pin_level;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R1";

    // Reference state, written from the requirements.
    bit         m_mode;
    logic [1:0] m_dir;
    logic [1:0] m_out;
    logic [1:0] m_hist[$];

    always #2 clk = ~clk;

    i2c_pad_override u_i2c_pad_override (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ctl_low   (ctl_low),
        .pad_in    (pad_in),
        .pad_low   (pad_low),
        .pin_level (pin_level)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, update the model at the
    // rising edge, compare 1 ns later.
    task automatic step(input bit we, input logic [1:0] a, input logic [1:0] d,
                        input logic [1:0] cl, input logic [1:0] pin);
        logic [1:0] exp_low;
        logic [1:0] exp_lvl;
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; ctl_low = cl; pad_in = pin;
        @(posedge clk);
        if (!rst_n) begin
            m_mode = 0; m_dir = 2'b00; m_out = 2'b11; m_hist.delete();
        end else begin
            m_hist.push_back(pin);
            if (m_hist.size() > 4) void'(m_hist.pop_front());
            if (we) begin
                case (a)
                    2'd0: m_mode = d[0];
                    2'd1: m_dir  = d;
                    2'd2: m_out  = m_out | d;
                    default: m_out = m_out & ~d;
                endcase
            end
        end
        #1;
        exp_low = m_mode ? (m_dir & ~m_out) : cl;
        exp_lvl = (m_hist.size() >= 2) ? m_hist[m_hist.size()-2] : 2'b11;
        check(cur_req, pad_low, exp_low);
        check("R8", pin_level, exp_lvl);
    endtask

    function automatic logic [1:0] rnd2();
        return 2'($urandom_range(0, 3));
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, rnd2(), rnd2(), rnd2(), rnd2());
    endtask

    initial begin
        // R1: reset values, then show the latches start released.
        cur_req = "R1";
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(0, 2'd0, 2'd0, rnd2(), rnd2());
        rst_n = 1'b1;
        step(0, 2'd0, 2'd0, 2'b01, 2'b00);
        check("R1", pin_level, 2'b11);
        step(1, 2'd0, 2'b01, 2'b11, 2'b00);
        step(1, 2'd1, 2'b11, 2'b11, 2'b10);
        check("R1", pad_low, 2'b00);
        step(1, 2'd0, 2'b00, 2'b10, 2'b01);

        // R2: controller mode passes requests; latches are ignored.
        cur_req = "R2";
        step(1, 2'd3, 2'b11, 2'b00, rnd2());
        check("R2", pad_low, 2'b00);
        for (int i = 0; i < 20; i++) step(0, rnd2(), rnd2(), rnd2(), rnd2());

        // R3: mode bit 0 of address 0; other bits ignored.
        cur_req = "R3";
        step(1, 2'd0, 2'b01, 2'b00, rnd2());
        check("R3", pad_low, 2'b11);
        step(1, 2'd0, 2'b10, 2'b01, rnd2());
        check("R3", pad_low, 2'b01);
        step(1, 2'd0, 2'b11, 2'b00, rnd2());

        // R4: pin mode ignores controller requests.
        cur_req = "R4";
        for (int i = 0; i < 20; i++) step(0, rnd2(), rnd2(), rnd2(), rnd2());

        // R5: direction bits per pin.
        cur_req = "R5";
        step(1, 2'd1, 2'b01, 2'b10, rnd2());
        check("R5", pad_low, 2'b01);
        step(1, 2'd1, 2'b10, 2'b01, rnd2());
        check("R5", pad_low, 2'b10);
        step(1, 2'd1, 2'b11, 2'b00, rnd2());

        // R6: set releases only the written pins.
        cur_req = "R6";
        step(1, 2'd2, 2'b01, 2'b11, rnd2());
        check("R6", pad_low, 2'b10);
        step(1, 2'd2, 2'b10, 2'b11, rnd2());
        check("R6", pad_low, 2'b00);

        // R7: clear pulls only the written pins.
        cur_req = "R7";
        step(1, 2'd3, 2'b10, 2'b00, rnd2());
        check("R7", pad_low, 2'b10);
        step(1, 2'd3, 2'b01, 2'b00, rnd2());
        check("R7", pad_low, 2'b11);

        // R9: inputs are never pulled even with cleared latches.
        cur_req = "R9";
        step(1, 2'd1, 2'b00, 2'b11, rnd2());
        check("R9", pad_low, 2'b00);
        idle(5);

        // R10: no write enable, no register change.
        cur_req = "R10";
        step(1, 2'd1, 2'b01, 2'b00, rnd2());
        for (int i = 0; i < 12; i++) step(0, rnd2(), rnd2(), rnd2(), rnd2());
        check("R10", pad_low, 2'b01);

        // R8 and the rest: random traffic in both modes.
        cur_req = "R8";
        for (int i = 0; i < 300; i++) step($urandom_range(0, 1) == 1, rnd2(), rnd2(), rnd2(), rnd2());

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule